// File: doc/BRIEF.md
# Halt and Bus-Release Controller

This block parks a small processor core on an instruction boundary when an active-low halt request is held low. Once the core is parked, the block raises a bus-released flag and takes the core off the system bus. It turns off the address, read/write and data output enables, and it holds the valid-address qualifier low so that no peripheral decodes the floating bus. The halt request is looked at only on the clock edge that ends the last cycle of an instruction. A request that arrives later is therefore served only after the next whole instruction.

Interrupt pending flags come from latches outside the block. They are passed to the core only while it runs, so anything that arrives during a halt waits and reaches the core in the first cycle after release. While reset is low the block forces a fixed bus state:

- valid-address and bus-released are low;
- the data enable is off;
- read/write is driven as read;
- the address lines carry the reset vector.

When reset is released the core starts in run.

Top module: `haltBusCtrl`

## Requirements
- R1: While `rstN` is low, `busAvail`=0, `vmaOut`=0, `dataOe`=0, `runEn`=0, `intOut`=0, `addrOe`=1, `rnwOe`=1, `rnwOut`=1 and `addrOut`=`RESET_VEC` (default 16'hFFFE). This holds whatever the halt and core inputs do, including when reset arrives during a halt.
- R2: A clock edge with `instrLast`=1 and `haltN`=0 while running makes `busAvail`=1 and `runEn`=0 from the next cycle on.
- R3: An edge with `instrLast`=0 never starts a halt. A `haltN` low that first appears after the last cycle of an instruction (for example, during the next opcode-fetch cycle) halts only after that next instruction's last cycle.
- R4: While halted, `addrOe`, `dataOe`, `rnwOe` and `vmaOut` are 0, `addrOut` is 0 and `rnwOut` is 1.
- R5: While running, `busAvail`=0 and `runEn`=1, both enables for address and read/write are 1, and `addrOut`, `rnwOut`, `vmaOut` and `dataOe` follow `coreAddr`, `coreRnW`, `coreVma` and `coreDataOe`.
- R6: `intOut` is {`nmiPend`,`irqPend`} (bit 1 is non-maskable) while running and 0 while halted. Flags pending at release appear in the first run cycle.
- R7: An edge with `haltN`=1 while halted gives `busAvail`=0 and `runEn`=1 in the next cycle. Both change in that same cycle.
- R8: While halted with `haltN` low, `instrLast` pulses have no effect: `busAvail` stays 1.
- R9: After `rstN` rises the block is running (`runEn`=1, `busAvail`=0, core address on `addrOut`), whatever the level of `haltN`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low reset, asynchronous |
| haltN | input | 1 | Active-low halt request, level sensitive |
| instrLast | input | 1 | High in the last cycle of an instruction |
| opFetch | input | 1 | High in an opcode-fetch cycle |
| irqPend | input | 1 | Latched maskable interrupt pending |
| nmiPend | input | 1 | Latched non-maskable interrupt pending |
| coreAddr | input | ADDR_W | Address from the core |
| coreRnW | input | 1 | Read (1) / write (0) from the core |
| coreVma | input | 1 | Core address-valid qualifier |
| coreDataOe | input | 1 | Core wants to drive the data bus |
| busAvail | output | 1 | High while the core is halted and off the bus |
| runEn | output | 1 | Run/stall control to the core sequencer |
| vmaOut | output | 1 | Valid-address qualifier to the bus |
| addrOe | output | 1 | Address bus output enable |
| addrOut | output | ADDR_W | Address bus value |
| rnwOe | output | 1 | Read/write line output enable |
| rnwOut | output | 1 | Read/write line value |
| dataOe | output | 1 | Data bus output enable |
| intOut | output | 2 | Pending interrupts passed to the core, {nmi, irq} |

## Verification
The assertions take it as given that the sequencer raises `opFetch` only while `runEn` is high. They also rely on all inputs changing away from the active edge, so each edge sees one clean halt and boundary level. The bench drives its inputs 1 ns after each rising edge. It raises `opFetch` only in cycles where the reference model says the core runs, and it holds reset over several edges so that the asynchronous clear and the model agree before release.

// File: rtl/haltBusPkg.sv
package haltBusPkg;

  typedef enum logic {
    ST_RUN  = 1'b0,
    ST_HALT = 1'b1
  } ctlState_t;

  // Strobes from the control FSM to the bus datapath
  typedef struct packed {
    logic busOn;     // core owns the bus
    logic forceVec;  // reset: drive the fixed reset bus state
    logic passInt;   // forward pending interrupts to the core
  } ctlStrobes_t;

endpackage

// File: rtl/haltCtrl.sv
module haltCtrl
  import haltBusPkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  logic        haltN,
  input  logic        instrLast,
  input  logic        opFetch,
  output logic        busAvail,
  output logic        runEn,
  output ctlStrobes_t strobes
);

  ctlState_t state, stateNext;

  always_comb begin
    stateNext = state;
    unique case (state)
      ST_RUN:  if (instrLast && !haltN) stateNext = ST_HALT;
      ST_HALT: if (haltN)               stateNext = ST_RUN;
      default:                          stateNext = ST_RUN;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) state <= ST_RUN;
    else       state <= stateNext;
  end

  always_comb begin
    busAvail         = rstN && (state == ST_HALT);
    runEn            = rstN && (state == ST_RUN);
    strobes.busOn    = rstN && (state == ST_RUN);
    strobes.forceVec = !rstN;
    strobes.passInt  = rstN && (state == ST_RUN);
  end

  // Halt taken on the boundary edge shows up on busAvail one cycle later
  assert_halt_on_boundary_R2: assert property (@(posedge clk) disable iff (!rstN)
    (!busAvail && instrLast && !haltN) |=> (busAvail && !runEn));

  // No halt begins from an edge that is not an instruction's last cycle
  assert_no_midinstr_halt_R3: assert property (@(posedge clk) disable iff (!rstN)
    (!busAvail && !instrLast) |=> !busAvail);

  // Release: busAvail falls in the same cycle run resumes
  assert_release_R7: assert property (@(posedge clk) disable iff (!rstN)
    (busAvail && haltN) |=> (!busAvail && runEn));

  // Boundary strobes are ignored while held halted
  assert_hold_halt_R8: assert property (@(posedge clk) disable iff (!rstN)
    (busAvail && !haltN) |=> busAvail);

  // Input assumption: the sequencer fetches only while allowed to run (R5)
  assert_fetch_in_run_R5: assert property (@(posedge clk) disable iff (!rstN)
    opFetch |-> runEn);

endmodule

// File: rtl/busPath.sv
module busPath
  import haltBusPkg::*;
#(
  parameter int unsigned         ADDR_W    = 16,
  parameter logic [ADDR_W-1:0]   RESET_VEC = 16'hFFFE
) (
  input  ctlStrobes_t       strobes,
  input  logic [ADDR_W-1:0] coreAddr,
  input  logic              coreRnW,
  input  logic              coreVma,
  input  logic              coreDataOe,
  input  logic              irqPend,
  input  logic              nmiPend,
  output logic              vmaOut,
  output logic              addrOe,
  output logic [ADDR_W-1:0] addrOut,
  output logic              rnwOe,
  output logic              rnwOut,
  output logic              dataOe,
  output logic [1:0]        intOut
);

  localparam logic [ADDR_W-1:0] ADDR_IDLE = '0;

  always_comb begin
    if (strobes.forceVec) begin
      addrOe  = 1'b1;
      addrOut = RESET_VEC;
      rnwOe   = 1'b1;
      rnwOut  = 1'b1;
      vmaOut  = 1'b0;
      dataOe  = 1'b0;
    end else if (strobes.busOn) begin
      addrOe  = 1'b1;
      addrOut = coreAddr;
      rnwOe   = 1'b1;
      rnwOut  = coreRnW;
      vmaOut  = coreVma;
      dataOe  = coreDataOe;
    end else begin
      addrOe  = 1'b0;
      addrOut = ADDR_IDLE;
      rnwOe   = 1'b0;
      rnwOut  = 1'b1;
      vmaOut  = 1'b0;
      dataOe  = 1'b0;
    end
    intOut = strobes.passInt ? {nmiPend, irqPend} : 2'b00;
  end

  // Reset bus state carries the vector and a read
  always_comb begin
    if (strobes.forceVec)
      assert_reset_bus_R1: assert (addrOut == RESET_VEC && rnwOut && !vmaOut && !dataOe);
  end

  // Released bus: every driver off, no valid-address qualifier
  always_comb begin
    if (!strobes.busOn && !strobes.forceVec)
      assert_bus_float_R4: assert (!addrOe && !dataOe && !rnwOe && !vmaOut);
  end

  // Interrupts held back while the core may not run
  always_comb begin
    if (!strobes.passInt)
      assert_int_held_R6: assert (intOut == 2'b00);
  end

endmodule

// File: rtl/haltBusCtrl.sv
module haltBusCtrl
  import haltBusPkg::*;
#(
  parameter int unsigned       ADDR_W    = 16,
  parameter logic [ADDR_W-1:0] RESET_VEC = 16'hFFFE
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              haltN,
  input  logic              instrLast,
  input  logic              opFetch,
  input  logic              irqPend,
  input  logic              nmiPend,
  input  logic [ADDR_W-1:0] coreAddr,
  input  logic              coreRnW,
  input  logic              coreVma,
  input  logic              coreDataOe,
  output logic              busAvail,
  output logic              runEn,
  output logic              vmaOut,
  output logic              addrOe,
  output logic [ADDR_W-1:0] addrOut,
  output logic              rnwOe,
  output logic              rnwOut,
  output logic              dataOe,
  output logic [1:0]        intOut
);

  ctlStrobes_t strobes;

  haltCtrl i_ctrl (
    .clk       (clk),
    .rstN      (rstN),
    .haltN     (haltN),
    .instrLast (instrLast),
    .opFetch   (opFetch),
    .busAvail  (busAvail),
    .runEn     (runEn),
    .strobes   (strobes)
  );

  busPath #(
    .ADDR_W    (ADDR_W),
    .RESET_VEC (RESET_VEC)
  ) i_path (
    .strobes    (strobes),
    .coreAddr   (coreAddr),
    .coreRnW    (coreRnW),
    .coreVma    (coreVma),
    .coreDataOe (coreDataOe),
    .irqPend    (irqPend),
    .nmiPend    (nmiPend),
    .vmaOut     (vmaOut),
    .addrOe     (addrOe),
    .addrOut    (addrOut),
    .rnwOe      (rnwOe),
    .rnwOut     (rnwOut),
    .dataOe     (dataOe),
    .intOut     (intOut)
  );

endmodule

// File: tb/test_haltBusCtrl.sv
`timescale 1ns/100ps
module test_haltBusCtrl;

  localparam int unsigned AW  = 16;
  localparam logic [AW-1:0] VEC = 16'hFFFE;

  logic clk = 1'b0;
  logic rstN = 1'b0, haltN = 1'b0, instrLast = 1'b0, opFetch = 1'b0;
  logic irqPend = 1'b0, nmiPend = 1'b0;
  logic [AW-1:0] coreAddr = 16'h1000;
  logic coreRnW = 1'b1, coreVma = 1'b1, coreDataOe = 1'b0;
  logic busAvail, runEn, vmaOut, addrOe, rnwOe, rnwOut, dataOe;
  logic [AW-1:0] addrOut;
  logic [1:0] intOut;

  int checks = 0;
  int errors = 0;
  int cyc = 0;
  bit mHalted = 1'b0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  haltBusCtrl #(.ADDR_W(AW), .RESET_VEC(VEC)) i_haltBusCtrl (
    .clk(clk), .rstN(rstN), .haltN(haltN), .instrLast(instrLast), .opFetch(opFetch),
    .irqPend(irqPend), .nmiPend(nmiPend), .coreAddr(coreAddr), .coreRnW(coreRnW),
    .coreVma(coreVma), .coreDataOe(coreDataOe), .busAvail(busAvail), .runEn(runEn),
    .vmaOut(vmaOut), .addrOe(addrOe), .addrOut(addrOut), .rnwOe(rnwOe),
    .rnwOut(rnwOut), .dataOe(dataOe), .intOut(intOut)
  );

  // Behavioural reference: halted flag only
  always @(posedge clk) begin
    if (rstN !== 1'b1)                         mHalted <= 1'b0;
    else if (!mHalted && instrLast && !haltN)  mHalted <= 1'b1;
    else if (mHalted && haltN)                 mHalted <= 1'b0;
  end

  task automatic finishRun();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  endtask

  // Compare every output with the model on each falling edge
  always @(negedge clk) begin
    logic [24:0] act, exp;
    string req;
    act = {busAvail, vmaOut, addrOe, dataOe, rnwOe, rnwOut, runEn, intOut, addrOut};
    if (!rstN) begin
      req = "R1";
      exp = {1'b0, 1'b0, 1'b1, 1'b0, 1'b1, 1'b1, 1'b0, 2'b00, VEC};
    end else if (mHalted) begin
      req = "R4";
      exp = {1'b1, 1'b0, 1'b0, 1'b0, 1'b0, 1'b1, 1'b0, 2'b00, {AW{1'b0}}};
    end else begin
      req = "R5";
      exp = {1'b0, coreVma, 1'b1, coreDataOe, 1'b1, coreRnW, 1'b1, nmiPend, irqPend, coreAddr};
    end
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s model compare t=%0t actual=%h expected=%h", req, $time, act, exp);
    end
  end

  always @(posedge clk) begin
    cyc++;
    if (cyc > 20000 && !done) begin
      errors++;
      $display("FAIL watchdog expired actual=%0d expected<=20000", cyc);
      finishRun();
    end
  end

  task automatic see(string req, string what, logic [AW-1:0] act, logic [AW-1:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  task automatic drv(logic h, logic l, logic f);
    @(posedge clk); #1;
    haltN = h; instrLast = l; opFetch = f;
    coreAddr = coreAddr + 16'h0123;
    coreRnW = ~coreRnW;
    coreDataOe = ~coreRnW;
    coreVma = 1'b1;
  endtask

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    see("R1", "reset addrOut", addrOut, VEC);
    see("R1", "reset rnwOut", {15'd0, rnwOut}, 16'd1);
    see("R1", "reset busAvail", {15'd0, busAvail}, 16'd0);
    see("R1", "reset vmaOut", {15'd0, vmaOut}, 16'd0);

    @(posedge clk); #1; rstN = 1'b1; haltN = 1'b1;
    @(negedge clk);
    see("R9", "runEn after reset", {15'd0, runEn}, 16'd1);

    for (int i = 0; i < 6; i++) drv(1'b1, i[0], !i[0]);
    @(negedge clk);
    see("R5", "addr passthrough", addrOut, coreAddr);
    see("R5", "dataOe passthrough", {15'd0, dataOe}, {15'd0, coreDataOe});

    // Two-cycle single-byte instruction, halt low in time for the last cycle
    drv(1'b1, 1'b0, 1'b1);
    drv(1'b0, 1'b1, 1'b0);
    drv(1'b0, 1'b0, 1'b0);
    @(negedge clk);
    see("R2", "busAvail after on-time halt", {15'd0, busAvail}, 16'd1);
    see("R2", "runEn after on-time halt", {15'd0, runEn}, 16'd0);

    irqPend = 1'b1; nmiPend = 1'b1;
    drv(1'b0, 1'b1, 1'b0);
    drv(1'b0, 1'b1, 1'b0);
    @(negedge clk);
    see("R8", "busAvail held", {15'd0, busAvail}, 16'd1);
    see("R6", "intOut while halted", {14'd0, intOut}, 16'd0);
    see("R4", "addrOe while halted", {15'd0, addrOe}, 16'd0);
    see("R4", "vmaOut while halted", {15'd0, vmaOut}, 16'd0);

    drv(1'b1, 1'b0, 1'b0);
    @(negedge clk);
    see("R7", "still halted before edge", {15'd0, busAvail}, 16'd1);
    drv(1'b1, 1'b0, 1'b1);
    @(negedge clk);
    see("R7", "busAvail released", {15'd0, busAvail}, 16'd0);
    see("R7", "runEn resumed", {15'd0, runEn}, 16'd1);
    see("R6", "intOut first run cycle", {14'd0, intOut}, 16'd3);
    drv(1'b1, 1'b1, 1'b0);
    irqPend = 1'b0; nmiPend = 1'b0;

    // Late halt: low only from the next opcode fetch
    drv(1'b1, 1'b0, 1'b1);
    drv(1'b1, 1'b1, 1'b0);
    drv(1'b0, 1'b0, 1'b1);
    @(negedge clk);
    see("R3", "late halt: fetch cycle runs", {15'd0, busAvail}, 16'd0);
    drv(1'b0, 1'b1, 1'b0);
    @(negedge clk);
    see("R3", "late halt: last cycle runs", {15'd0, busAvail}, 16'd0);
    drv(1'b0, 1'b0, 1'b0);
    @(negedge clk);
    see("R3", "late halt: halted after next instr", {15'd0, busAvail}, 16'd1);

    // Reset while halted
    @(posedge clk); #1; rstN = 1'b0;
    @(negedge clk);
    see("R1", "reset in halt addrOut", addrOut, VEC);
    see("R1", "reset in halt busAvail", {15'd0, busAvail}, 16'd0);
    see("R1", "reset in halt rnwOe", {15'd0, rnwOe}, 16'd1);
    drv(1'b0, 1'b0, 1'b0);
    drv(1'b0, 1'b0, 1'b0);
    @(negedge clk);
    see("R1", "reset rnwOut while core writes", {15'd0, rnwOut}, 16'd1);
    @(posedge clk); #1; rstN = 1'b1;
    @(negedge clk);
    see("R9", "run after reset with halt low", {15'd0, runEn}, 16'd1);
    see("R9", "core addr after reset", addrOut, coreAddr);

    // Halt low only inside an instruction, high again at its last cycle
    drv(1'b0, 1'b0, 1'b1);
    drv(1'b1, 1'b1, 1'b0);
    drv(1'b1, 1'b0, 1'b1);
    @(negedge clk);
    see("R3", "mid-instruction pulse ignored", {15'd0, busAvail}, 16'd0);

    repeat (3) drv(1'b1, 1'b0, 1'b0);
    @(negedge clk);
    done = 1'b1;
    finishRun();
  end

endmodule